// File: doc/BRIEF.md
# Fraction to Exponent-Fraction Pair Converter

The block moves values between a signed two's-complement fixed-point fraction and a two-word floating representation. That representation pairs a 16-bit signed exponent with a signed fraction of the same width as the fixed-point value. The width is 16 bits for the short variant and 32 bits for the long variant, and the `FRAC_W` parameter picks between them.

The block has two independent paths that run side by side, and each path ends in one output register.

- **Forward path.** It normalizes a fixed-point input. It counts how many bits directly below the sign bit repeat the sign. It shifts the input left by that count and reports the negated count as the exponent.
- **Reverse path.** It denormalizes an exponent-fraction pair back to fixed point. It applies one arithmetic shift whose direction and distance come from the signed exponent. A left shift that would lose significant bits clamps to the extreme value. A right shift by at least the fraction width fills with the sign.

Top module: `ffc_conv`

## Requirements
- R1: While `rst_ni` is low, `frac_o`, `exp_o` and `fix_o` are all zero.
- R2: Every output is registered. A value appears on the outputs after the first rising `clk_i` edge at which the inputs are sampled, and the outputs keep their previous value until that edge.
- R3: `exp_o` equals minus the count of redundant sign bits of `fix_i`, written as a 16-bit two's-complement value. Redundant sign bits are the consecutive bits directly below the MSB that are equal to the MSB. `exp_o` always lies in the range -(FRAC_W-1) to 0.
- R4: `frac_o` equals `fix_i` shifted left by that count. For any nonzero input, bit FRAC_W-1 of `frac_o` differs from bit FRAC_W-2.
- R5: A zero input gives `frac_o` = 0 and `exp_o` = -(FRAC_W-1). An all-ones input (-1 LSB) gives `frac_o` = 1 followed by zeros, and `exp_o` = -(FRAC_W-1).
- R6: For a negative `exp_i` = -k, `fix_o` equals `frac_i` shifted arithmetically right by k, which rounds toward minus infinity. When k >= FRAC_W, `fix_o` is all zeros for a non-negative `frac_i` and all ones for a negative one.
- R7: For a non-negative `exp_i` = k, `fix_o` equals `frac_i` shifted left by k in either of two cases: `frac_i` is zero, or the shifted value still fits in FRAC_W signed bits.
- R8: When a left shift under R7 would not fit, `fix_o` saturates. It becomes 0 followed by ones for a positive `frac_i`, and 1 followed by zeros for a negative one.
- R9: With `FRAC_W` = 32, all of R3 to R8 hold for 32-bit fractions with the same 16-bit exponent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every output register samples on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fix_i | input | FRAC_W | Fixed-point fraction to be normalized |
| frac_i | input | FRAC_W | Fraction word of the pair to be denormalized |
| exp_i | input | 16 | Signed exponent word of the pair to be denormalized |
| frac_o | output | FRAC_W | Normalized fraction word |
| exp_o | output | 16 | Signed exponent word; minus the sign-bit count |
| fix_o | output | FRAC_W | Fixed-point result of the denormalizing shift |

## Verification
The assertions take for granted that every input is driven to a known value and held steady across each rising edge. The forward round-trip property and the fill and saturation properties compare registered outputs with the inputs of the cycle before, so they depend on this. The stimulus changes inputs only on falling edges and always drives full binary values. Every possible 16-bit forward input is swept. The exponent stimulus includes the 16-bit extremes, so the magnitude of -32768 and large left shifts of a zero fraction are both covered.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  localparam int EXP_W = 16;

  typedef enum logic [1:0] {
    SH_RIGHT,
    SH_LEFT,
    SH_SAT,
    SH_FILL
  } shift_mode_e;
endpackage

// File: rtl/ffc_sign_count.sv
module ffc_sign_count #(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W)
) (
  input  logic [W-1:0]     val_i,
  output logic [CNT_W-1:0] cnt_o
);
  // count run of bits below the MSB that repeat it
  always_comb begin
    logic run_ok;
    run_ok = 1'b1;
    cnt_o  = '0;
    for (int i = W - 2; i >= 0; i--) begin
      run_ok = run_ok & (val_i[i] == val_i[W-1]);
      cnt_o  = cnt_o + CNT_W'(run_ok);
    end
  end
endmodule

// File: rtl/ffc_barrel.sv
module ffc_barrel #(
  parameter int W        = 16,
  parameter int CNT_W    = $clog2(W),
  parameter bit TO_RIGHT = 1'b0
) (
  input  logic [W-1:0]     val_i,
  input  logic [CNT_W-1:0] amt_i,
  output logic [W-1:0]     val_o
);
  for (genvar s = 0; s < CNT_W; s++) begin : g_stg
    logic [W-1:0] src;
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      assign src = val_i;
    end else begin : g_next
      assign src = g_stg[s-1].q;
    end
    if (TO_RIGHT) begin : g_shr
      assign q = amt_i[s] ? W'($signed(src) >>> (1 << s)) : src;
    end else begin : g_shl
      assign q = amt_i[s] ? W'(src << (1 << s)) : src;
    end
  end

  assign val_o = g_stg[CNT_W-1].q;
endmodule

// File: rtl/ffc_denorm.sv
module ffc_denorm
  import ffc_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W)
) (
  input  logic [W-1:0]     frac_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [W-1:0]     fix_o
);
  logic [CNT_W-1:0] head_cnt;
  logic [EXP_W:0]   mag;
  logic             neg, big, over, zero, sgn;
  logic [W-1:0]     shl, shr;
  shift_mode_e      mode;

  ffc_sign_count #(.W(W), .CNT_W(CNT_W)) u_cnt (
    .val_i (frac_i),
    .cnt_o (head_cnt)
  );

  assign neg  = exp_i[EXP_W-1];
  // 17-bit magnitude so that -32768 stays exact
  assign mag  = neg ? (~{1'b1, exp_i}) + (EXP_W+1)'(1) : {1'b0, exp_i};
  assign big  = mag >= (EXP_W+1)'(W);
  assign over = mag > (EXP_W+1)'(head_cnt);
  assign zero = (frac_i == '0);
  assign sgn  = frac_i[W-1];

  always_comb begin
    if (neg)               mode = big ? SH_FILL : SH_RIGHT;
    else if (!zero && over) mode = SH_SAT;
    else                   mode = SH_LEFT;
  end

  ffc_barrel #(.W(W), .CNT_W(CNT_W), .TO_RIGHT(1'b1)) u_shr (
    .val_i (frac_i),
    .amt_i (mag[CNT_W-1:0]),
    .val_o (shr)
  );

  ffc_barrel #(.W(W), .CNT_W(CNT_W), .TO_RIGHT(1'b0)) u_shl (
    .val_i (frac_i),
    .amt_i (mag[CNT_W-1:0]),
    .val_o (shl)
  );

  always_comb begin
    case (mode)
      SH_RIGHT: fix_o = shr;
      SH_LEFT:  fix_o = shl;
      SH_SAT:   fix_o = sgn ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      SH_FILL:  fix_o = {W{sgn}};
    endcase
  end
endmodule

// File: rtl/ffc_conv.sv
module ffc_conv
  import ffc_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] fix_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] fix_o
);
  localparam int CNT_W = $clog2(FRAC_W);

  if (!(FRAC_W == 16 || FRAC_W == 32)) begin : g_bad_w
    $error("ffc_conv: FRAC_W must be 16 or 32");
  end

  logic [CNT_W-1:0]  fwd_cnt;
  logic [FRAC_W-1:0] fwd_frac, rev_fix;
  logic [EXP_W-1:0]  fwd_exp;

  ffc_sign_count #(.W(FRAC_W), .CNT_W(CNT_W)) u_fwd_cnt (
    .val_i (fix_i),
    .cnt_o (fwd_cnt)
  );

  ffc_barrel #(.W(FRAC_W), .CNT_W(CNT_W), .TO_RIGHT(1'b0)) u_fwd_shl (
    .val_i (fix_i),
    .amt_i (fwd_cnt),
    .val_o (fwd_frac)
  );

  assign fwd_exp = EXP_W'(0) - EXP_W'(fwd_cnt);

  ffc_denorm #(.W(FRAC_W), .CNT_W(CNT_W)) u_rev (
    .frac_i (frac_i),
    .exp_i  (exp_i),
    .fix_o  (rev_fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_o <= '0;
      exp_o  <= '0;
      fix_o  <= '0;
    end else begin
      frac_o <= fwd_frac;
      exp_o  <= fwd_exp;
      fix_o  <= rev_fix;
    end
  end
endmodule

// File: rtl/ffc_conv_chk.sv
module ffc_conv_chk
  import ffc_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FRAC_W-1:0] fix_i,
  input logic [FRAC_W-1:0] frac_i,
  input logic [EXP_W-1:0]  exp_i,
  input logic [FRAC_W-1:0] frac_o,
  input logic [EXP_W-1:0]  exp_o,
  input logic [FRAC_W-1:0] fix_o
);
  logic [EXP_W-1:0]  back_amt;
  logic [FRAC_W-1:0] back_val;
  logic [FRAC_W-1:0] sat_pos, sat_neg;

  assign back_amt = EXP_W'(0) - exp_o;
  assign back_val = FRAC_W'($signed(frac_o) >>> back_amt);
  assign sat_pos  = {1'b0, {(FRAC_W-1){1'b1}}};
  assign sat_neg  = {1'b1, {(FRAC_W-1){1'b0}}};

  a_r3_exp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(exp_o) <= 0) && ($signed(exp_o) >= -(FRAC_W - 1)));

  // R3/R4: undoing the normalization restores the input
  a_r3_roundtrip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (back_val == $past(fix_i)));

  a_r4_normalized: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_i != '0) |=> (frac_o[FRAC_W-1] != frac_o[FRAC_W-2]));

  a_r6_sign_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(exp_i) <= -FRAC_W) |=> (fix_o == {FRAC_W{$past(frac_i[FRAC_W-1])}}));

  a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exp_i[EXP_W-1] && (frac_i != '0) && ($signed(exp_i) >= FRAC_W))
    |=> (fix_o == ($past(frac_i[FRAC_W-1]) ? sat_neg : sat_pos)));
endmodule

bind ffc_conv ffc_conv_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .fix_i  (fix_i),
  .frac_i (frac_i),
  .exp_i  (exp_i),
  .frac_o (frac_o),
  .exp_o  (exp_o),
  .fix_o  (fix_o)
);

// File: tb/ffc_conv_tb_top.sv
`timescale 1ns/1ps
module ffc_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] fix16 = '0, frac16 = '0, exp16 = '0;
  logic [31:0] fix32 = '0, frac32 = '0;
  logic [15:0] frac16_o, exp16_o, fix16_o, exp32_o;
  logic [31:0] frac32_o, fix32_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ffc_conv #(.FRAC_W(16)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .fix_i (fix16), .frac_i (frac16), .exp_i (exp16),
    .frac_o (frac16_o), .exp_o (exp16_o), .fix_o (fix16_o)
  );

  ffc_conv #(.FRAC_W(32)) dut_long_i (
    .clk_i (clk), .rst_ni (rst_n), .fix_i (fix32), .frac_i (frac32), .exp_i (exp16),
    .frac_o (frac32_o), .exp_o (exp32_o), .fix_o (fix32_o)
  );

  function automatic longint sx(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  function automatic longint ref_cnt(longint v, int w);
    longint c = 0;
    for (int i = w - 2; i >= 0; i--) begin
      if (((v >>> i) & 1) == ((v >>> (w - 1)) & 1)) c++;
      else break;
    end
    return c;
  endfunction

  function automatic bit ref_sat(longint f, longint e, int w);
    longint p;
    if (e < 0 || f == 0) return 1'b0;
    if (e >= w) return 1'b1;
    p = f <<< e;
    return p != sx(p, w);
  endfunction

  function automatic longint ref_rev(longint f, longint e, int w);
    longint mx = (64'sd1 <<< (w - 1)) - 1;
    if (e < 0) begin
      if (-e >= w) return (f < 0) ? -1 : 0;
      return f >>> (-e);
    end
    if (ref_sat(f, e, w)) return (f < 0) ? -mx - 1 : mx;
    return f <<< e;
  endfunction

  function automatic string pick(string forced, string dflt);
    return (forced == "") ? dflt : forced;
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic verify_vec(logic [15:0] a, logic [15:0] f, logic [15:0] e,
                            logic [31:0] a32, logic [31:0] f32, string forced);
    longint v, c, ee, fv;
    string  t5, tr;
    v  = sx(longint'(a), 16);
    c  = ref_cnt(v, 16);
    t5 = (v == 0 || v == -1) ? "R5" : "";
    check(pick(forced, pick(t5, "R4")), "frac16", sx(longint'(frac16_o), 16), sx(v <<< c, 16));
    check(pick(forced, pick(t5, "R3")), "exp16", sx(longint'(exp16_o), 16), -c);
    ee = sx(longint'(e), 16);
    fv = sx(longint'(f), 16);
    tr = (ee < 0) ? "R6" : (ref_sat(fv, ee, 16) ? "R8" : "R7");
    check(pick(forced, tr), "fix16", sx(longint'(fix16_o), 16), ref_rev(fv, ee, 16));
    v  = sx(longint'(a32), 32);
    c  = ref_cnt(v, 32);
    check(pick(forced, "R9"), "frac32", sx(longint'(frac32_o), 32), sx(v <<< c, 32));
    check(pick(forced, "R9"), "exp32", sx(longint'(exp32_o), 16), -c);
    fv = sx(longint'(f32), 32);
    check(pick(forced, "R9"), "fix32", sx(longint'(fix32_o), 32), ref_rev(fv, ee, 32));
  endtask

  task automatic apply(logic [15:0] a, logic [15:0] f, logic [15:0] e,
                       logic [31:0] a32, logic [31:0] f32);
    @(negedge clk);
    fix16 = a; frac16 = f; exp16 = e; fix32 = a32; frac32 = f32;
    @(posedge clk);
    #1;
    verify_vec(a, f, e, a32, f32, "");
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  logic [15:0] edge16 [5] = '{16'h0000, 16'hffff, 16'h7fff, 16'h8000, 16'h0001};
  logic [31:0] edge32 [5] = '{32'h0, 32'hffffffff, 32'h7fffffff, 32'h80000000, 32'h1};
  int          exps [13]  = '{0, 1, -1, 15, 16, -15, -16, 31, 32, -31, -32, 32767, -32768};

  initial begin
    fix16 = 16'h1234; frac16 = 16'h4321; exp16 = 16'h0003;
    fix32 = 32'h1234; frac32 = 32'h4321;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs held at zero during reset
    check("R1", "frac16", longint'(frac16_o), 0);
    check("R1", "exp16", longint'(exp16_o), 0);
    check("R1", "fix16", longint'(fix16_o), 0);
    check("R1", "frac32", longint'(frac32_o), 0);
    check("R1", "fix32", longint'(fix32_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 13; c++)
          apply(edge16[a], edge16[b], 16'(exps[c]), edge32[a], edge32[b]);

    for (int i = 0; i < 65536; i++)
      apply(16'(i), 16'(i * 40503), 16'(i % 81 - 40),
            {16'(i), 16'(i * 7919)}, {16'(i * 40503), ~16'(i * 40503)});

    // R2: outputs keep the old value until the next rising edge
    apply(16'h0300, 16'h0123, 16'h0002, 32'h00070000, 32'h00001234);
    @(negedge clk);
    fix16 = 16'hf000; frac16 = 16'hff00; exp16 = 16'hfffc;
    fix32 = 32'h00000005; frac32 = 32'h80000000;
    #1;
    verify_vec(16'h0300, 16'h0123, 16'h0002, 32'h00070000, 32'h00001234, "R2");
    @(posedge clk);
    #1;
    verify_vec(16'hf000, 16'hff00, 16'hfffc, 32'h00000005, 32'h80000000, "");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end
endmodule